// File: doc/BRIEF.md
# Dual-Edge Sample Stream Interleaver

This block turns the parallel output words of a dual-channel converter running in dual-edge sampling mode back into a single, time-ordered sample stream. The two channels sample one input on opposite edges of the sampling clock. The data words therefore arrive grouped by channel and must be put back into true sampling order. The reconstructed stream carries two samples per sampling-clock period, so each output word covers half a period. The time order of the words does not depend on which analog input (I by default, or Q) feeds the interleaved path.

Two input arrangements are handled, and `modeDemux` chooses between them. In the 1:4 demux arrangement, one group strobe delivers four 10-bit words at once: the delayed Q word, the delayed I word, the current Q word and the current I word. Their time order runs in that sequence, from earliest to latest. In the non-demux arrangement, each data-clock edge delivers only a current Q and a current I word. Each edge is modelled as an edge strobe in the single clock domain, and Q is the earlier of the two. Words leave one per cycle on a valid/ready output, each with a 2-bit slot tag. The block buffers one group and accepts the next group only as the present one drains. A change of mode therefore applies only from the next accepted group onward.

Top module: `desInterleaver`

## Requirements
- R1: After a synchronous active-high reset, `outValid` is 0 and `inReady` is 1.
- R2: In demux mode (`modeDemux`=1), a group accepted on `grpStb` is emitted as four words in the order dlyQ, dlyI, curQ, curI. The tags are 0, 1, 2 and 3, and the first word is valid in the cycle after acceptance.
- R3: In non-demux mode (`modeDemux`=0), a pair accepted on `edgeStb` is emitted as two words, curQ then curI, with tags 2 and 3.
- R4: While a group is held, `inReady` is 0 except in a cycle where the final word (tag 3) is being handed off (`outValid` and `outReady`). Strobes arriving while `inReady` is 0 are ignored and do not change the buffered words.
- R5: While `outValid` is 1 and `outReady` is 0, `outValid`, `outData` and `outTag` stay unchanged.
- R6: A change of `modeDemux` while a group is held does not alter that group: its remaining words are emitted in order, and the new mode applies to the next accepted group.
- R7: A strobe presented in the cycle where the final word is handed off is accepted. The first word of the new group is valid in the next cycle, with no idle cycle between the groups.
- R8: The strobe of the mode not selected (`edgeStb` in demux mode, `grpStb` in non-demux mode) is ignored: `outValid` stays 0.
- R9: A reset while a group is partly emitted discards the rest of that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| modeDemux | input | 1 | 1 = 1:4 demux arrangement, 0 = non-demux |
| grpStb | input | 1 | Four-word group present (demux mode) |
| edgeStb | input | 1 | Q/I pair present for one data-clock edge (non-demux mode) |
| dlyQ | input | 10 | Delayed Q-channel word |
| dlyI | input | 10 | Delayed I-channel word |
| curQ | input | 10 | Current Q-channel word |
| curI | input | 10 | Current I-channel word |
| inReady | output | 1 | A strobe in this cycle is accepted |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Downstream takes the output word |
| outData | output | 10 | Output sample word |
| outTag | output | 2 | Source slot: 0 dlyQ, 1 dlyI, 2 curQ, 3 curI |

## Verification
A wrong read pointer shows up at once on `outTag`: a tag appears out of ascending order, or a pair starts at a tag other than 2, in the first cycle after the fault. A wrong hold flag shows up at `inReady` within one cycle. The bench can see this as a strobe accepted over a held group, which replaces the words still to be emitted, or as a missing `outValid` after a strobe that should have been accepted. Storage faults show up as wrong `outData` against the known words of each group, and backpressure makes a drifting output visible while the output is stalled.

// File: rtl/desIlvPkg.sv
package desIlvPkg;
  parameter int DATA_W = 10;
  parameter int SLOT_N = 4;
  localparam int IDX_W = $clog2(SLOT_N);
  localparam int PAIR_BASE = SLOT_N - 2;

  typedef logic [DATA_W-1:0] word_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             loadGrp;
    logic             loadPair;
    logic [IDX_W-1:0] rdIdx;
  } ilvStrobe_t;
endpackage

// File: rtl/desIlvCtrl.sv
module desIlvCtrl
  import desIlvPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       modeDemux,
  input  logic       grpStb,
  input  logic       edgeStb,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output ilvStrobe_t stb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOT_N - 1);
  localparam logic [IDX_W-1:0] PAIR_IDX = IDX_W'(PAIR_BASE);

  logic             busy;
  logic [IDX_W-1:0] ptr;
  logic             handOff;
  logic             lastHandOff;
  logic             acceptGrp;
  logic             acceptPair;

  assign handOff     = busy && outReady;
  assign lastHandOff = handOff && (ptr == LAST_IDX);
  assign inReady     = !busy || lastHandOff;
  assign acceptGrp   = inReady && modeDemux && grpStb;
  assign acceptPair  = inReady && !modeDemux && edgeStb;
  assign outValid    = busy;

  always_comb begin
    stb.loadGrp  = acceptGrp;
    stb.loadPair = acceptPair;
    stb.rdIdx    = ptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ptr  <= '0;
    end else if (acceptGrp) begin
      busy <= 1'b1;
      ptr  <= '0;
    end else if (acceptPair) begin
      busy <= 1'b1;
      ptr  <= PAIR_IDX;
    end else if (handOff) begin
      if (ptr == LAST_IDX) begin
        busy <= 1'b0;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/desIlvData.sv
module desIlvData
  import desIlvPkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  ilvStrobe_t             stb,
  input  logic [SLOT_N-1:0][DATA_W-1:0] inWords,
  output logic [DATA_W-1:0]      outData,
  output logic [IDX_W-1:0]       outTag
);
  logic [SLOT_N-1:0][DATA_W-1:0] slots;

  for (genvar i = 0; i < SLOT_N; i++) begin : g_slot
    if (i >= PAIR_BASE) begin : g_shared
      always_ff @(posedge clk) begin
        if (rst)
          slots[i] <= '0;
        else if (stb.loadGrp || stb.loadPair)
          slots[i] <= inWords[i];
      end
    end else begin : g_demuxOnly
      always_ff @(posedge clk) begin
        if (rst)
          slots[i] <= '0;
        else if (stb.loadGrp)
          slots[i] <= inWords[i];
      end
    end
  end

  assign outData = slots[stb.rdIdx];
  assign outTag  = stb.rdIdx;
endmodule

// File: rtl/desInterleaver.sv
module desInterleaver
  import desIlvPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              modeDemux,
  input  logic              grpStb,
  input  logic              edgeStb,
  input  logic [DATA_W-1:0] dlyQ,
  input  logic [DATA_W-1:0] dlyI,
  input  logic [DATA_W-1:0] curQ,
  input  logic [DATA_W-1:0] curI,
  output logic              inReady,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic [IDX_W-1:0]  outTag
);
  ilvStrobe_t stb;
  logic [SLOT_N-1:0][DATA_W-1:0] inWords;

  // slot index equals sampling order, earliest first
  assign inWords = {curI, curQ, dlyI, dlyQ};

  desIlvCtrl i_ctrl (
    .clk(clk), .rst(rst), .modeDemux(modeDemux), .grpStb(grpStb),
    .edgeStb(edgeStb), .outReady(outReady), .inReady(inReady),
    .outValid(outValid), .stb(stb)
  );

  desIlvData i_data (
    .clk(clk), .rst(rst), .stb(stb), .inWords(inWords),
    .outData(outData), .outTag(outTag)
  );
endmodule

// File: rtl/desIlvChk.sv
module desIlvChk
  import desIlvPkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              modeDemux,
  input logic              grpStb,
  input logic              edgeStb,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic [IDX_W-1:0]  outTag
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOT_N - 1);
  localparam logic [IDX_W-1:0] PAIR_IDX = IDX_W'(PAIR_BASE);

  logic rstPrev = 1'b0;
  always_ff @(posedge clk) rstPrev <= rst;

  // R1, R9: state after reset
  always_ff @(posedge clk) begin
    if (rstPrev && !rst)
      assert_reset_state_R1: assert (!outValid && inReady);
  end

  assert_demux_start_R2: assert property (@(posedge clk) disable iff (rst)
    inReady && modeDemux && grpStb |=> outValid && outTag == '0);

  assert_tag_order_R2: assert property (@(posedge clk) disable iff (rst)
    outValid && outReady && outTag != LAST_IDX |=>
      outValid && outTag == ($past(outTag) + 1'b1));

  assert_pair_start_R3: assert property (@(posedge clk) disable iff (rst)
    inReady && !modeDemux && edgeStb |=> outValid && outTag == PAIR_IDX);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    outValid && inReady |-> outReady && outTag == LAST_IDX);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outTag));

  assert_idle_ignore_R8: assert property (@(posedge clk) disable iff (rst)
    !outValid && ((modeDemux && !grpStb) || (!modeDemux && !edgeStb)) |=> !outValid);
endmodule

bind desInterleaver desIlvChk i_chk (
  .clk(clk), .rst(rst), .modeDemux(modeDemux), .grpStb(grpStb),
  .edgeStb(edgeStb), .inReady(inReady), .outValid(outValid),
  .outReady(outReady), .outData(outData), .outTag(outTag)
);

// File: tb/test_desInterleaver.sv
module test_desInterleaver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       modeDemux = 1'b1;
  logic       grpStb = 1'b0;
  logic       edgeStb = 1'b0;
  logic [9:0] dlyQ = '0, dlyI = '0, curQ = '0, curI = '0;
  logic       inReady, outValid;
  logic       outReady = 1'b1;
  logic [9:0] outData;
  logic [1:0] outTag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  desInterleaver i_desInterleaver (
    .clk(clk), .rst(rst), .modeDemux(modeDemux), .grpStb(grpStb),
    .edgeStb(edgeStb), .dlyQ(dlyQ), .dlyI(dlyI), .curQ(curQ), .curI(curI),
    .inReady(inReady), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outTag(outTag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic setWords(input [9:0] a, input [9:0] b, input [9:0] c, input [9:0] d);
    dlyQ = a; dlyI = b; curQ = c; curI = d;
  endtask

  // at negedge: expect word and tag, then advance
  task automatic expectWord(input string req, input [9:0] d, input [1:0] t);
    @(negedge clk);
    check({req, " valid"}, int'(outValid), 1);
    check({req, " data"}, int'(outData), int'(d));
    check({req, " tag"}, int'(outTag), int'(t));
    step();
  endtask

  task automatic expectIdle(input string req);
    @(negedge clk);
    check({req, " idle"}, int'(outValid), 0);
    step();
  endtask

  task automatic pushGrp(input [9:0] a, input [9:0] b, input [9:0] c, input [9:0] d);
    setWords(a, b, c, d);
    grpStb = 1'b1;
    step();
    grpStb = 1'b0;
  endtask

  task automatic pushPair(input [9:0] q, input [9:0] i);
    curQ = q; curI = i;
    edgeStb = 1'b1;
    step();
    edgeStb = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 outValid", int'(outValid), 0);
    check("R1 inReady", int'(inReady), 1);
    step();
  endtask

  task automatic testDemux();
    modeDemux = 1'b1;
    pushGrp(10'h101, 10'h202, 10'h303, 10'h3FF);
    expectWord("R2 w0", 10'h101, 2'd0);
    expectWord("R2 w1", 10'h202, 2'd1);
    expectWord("R2 w2", 10'h303, 2'd2);
    expectWord("R2 w3", 10'h3FF, 2'd3);
    expectIdle("R2 end");
  endtask

  task automatic testPair();
    modeDemux = 1'b0;
    setWords(10'h0AA, 10'h0BB, 10'h000, 10'h000);
    pushPair(10'h011, 10'h022);
    expectWord("R3 q0", 10'h011, 2'd2);
    expectWord("R3 i0", 10'h022, 2'd3);
    pushPair(10'h3C0, 10'h00F);
    expectWord("R3 q1", 10'h3C0, 2'd2);
    expectWord("R3 i1", 10'h00F, 2'd3);
    expectIdle("R3 end");
  endtask

  task automatic testBackpressure();
    modeDemux = 1'b1;
    pushGrp(10'h041, 10'h042, 10'h043, 10'h044);
    outReady = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R5 stall valid", int'(outValid), 1);
      check("R5 stall data", int'(outData), 10'h041);
      check("R5 stall tag", int'(outTag), 0);
      check("R4 stall ready", int'(inReady), 0);
      step();
    end
    // strobe while busy must be ignored
    setWords(10'h1E1, 10'h1E2, 10'h1E3, 10'h1E4);
    grpStb = 1'b1;
    @(negedge clk);
    check("R4 busy ready", int'(inReady), 0);
    step();
    grpStb = 1'b0;
    outReady = 1'b1;
    expectWord("R4 w0", 10'h041, 2'd0);
    expectWord("R4 w1", 10'h042, 2'd1);
    expectWord("R4 w2", 10'h043, 2'd2);
    expectWord("R4 w3", 10'h044, 2'd3);
    expectIdle("R4 end");
  endtask

  task automatic testBackToBack();
    modeDemux = 1'b1;
    pushGrp(10'h051, 10'h052, 10'h053, 10'h054);
    expectWord("R7 a0", 10'h051, 2'd0);
    expectWord("R7 a1", 10'h052, 2'd1);
    expectWord("R7 a2", 10'h053, 2'd2);
    setWords(10'h061, 10'h062, 10'h063, 10'h064);
    grpStb = 1'b1;
    @(negedge clk);
    check("R7 last tag", int'(outTag), 3);
    check("R7 last data", int'(outData), 10'h054);
    check("R7 ready on last", int'(inReady), 1);
    step();
    grpStb = 1'b0;
    expectWord("R7 b0", 10'h061, 2'd0);
    expectWord("R7 b1", 10'h062, 2'd1);
    expectWord("R7 b2", 10'h063, 2'd2);
    expectWord("R7 b3", 10'h064, 2'd3);
    expectIdle("R7 end");
  endtask

  task automatic testModeChange();
    modeDemux = 1'b1;
    pushGrp(10'h071, 10'h072, 10'h073, 10'h074);
    expectWord("R6 w0", 10'h071, 2'd0);
    modeDemux = 1'b0;
    expectWord("R6 w1", 10'h072, 2'd1);
    expectWord("R6 w2", 10'h073, 2'd2);
    expectWord("R6 w3", 10'h074, 2'd3);
    pushPair(10'h081, 10'h082);
    expectWord("R6 q", 10'h081, 2'd2);
    expectWord("R6 i", 10'h082, 2'd3);
    expectIdle("R6 end");
  endtask

  task automatic testWrongStrobe();
    modeDemux = 1'b1;
    edgeStb = 1'b1;
    step();
    edgeStb = 1'b0;
    expectIdle("R8 edge in demux");
    modeDemux = 1'b0;
    grpStb = 1'b1;
    step();
    grpStb = 1'b0;
    expectIdle("R8 grp in pair mode");
  endtask

  task automatic testResetMid();
    modeDemux = 1'b1;
    pushGrp(10'h091, 10'h092, 10'h093, 10'h094);
    expectWord("R9 w0", 10'h091, 2'd0);
    rst = 1'b1;
    step();
    rst = 1'b0;
    @(negedge clk);
    check("R9 valid", int'(outValid), 0);
    check("R9 ready", int'(inReady), 1);
    step();
    expectIdle("R9 stays idle");
  endtask

  initial begin
    step(); step();
    rst = 1'b0;
    testReset();
    testDemux();
    testPair();
    testBackpressure();
    testBackToBack();
    testModeChange();
    testWrongStrobe();
    testResetMid();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule